// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

The block produces a set of pulse-width-modulated outputs that all run on one common period. A single 8-bit prescaler divides the input clock. The divided clock advances a shared 8-bit local counter, so one period is always 256 local cycles, or (prescale + 1) × 256 input clocks. The period can only be changed through the prescaler. Each channel compares the shared counter against its own duty value. Its output stays high for duty + 1 local cycles, so a duty of 255 gives a constant high level.

Software reaches the block through a simple 32-bit word-addressed register port with separate read and write strobes. The port holds one duty register per channel, a control word and an interrupt-enable word. The control word carries the prescaler as two nibbles in separate fields, plus one run bit that starts or stops every channel together. A duty value written while the block runs is held in a staging register. It moves into the comparator only when the local counter wraps, so a running pulse is never cut short or stretched.

Top module: `pwm_shared_period`

## Requirements
- R1: After reset all registers read 0, every output is low, irq_en is 0 and rdata is 0.
- R2: Channel n's duty register sits at byte address 4·n. It stores wdata[7:0], and a read returns that value with bits 31:8 as 0.
- R3: The control word sits at byte address 0x50. Prescaler bits 3:0 are stored in control bits 3:0, prescaler bits 7:4 in control bits 14:11, and the run bit in bit 9. All other bits read 0, so writing all ones reads back 0x00007A0F.
- R4: The word at byte address 0x54 stores an interrupt-enable flag in bit 0. The flag reads back in bit 0 (other bits 0) and appears on irq_en.
- R5: Reads of unmapped or misaligned (addr[1:0] ≠ 0) addresses return 0, and writes to them change no register. rdata is valid in the cycle after rd_en and is 0 otherwise.
- R6: While running, every output repeats with a period of 256·(prescale + 1) clocks. All channels start their high phase in the same cycle.
- R7: Each output is high for (duty + 1)·(prescale + 1) clocks per period and low for the rest. A duty of 255 keeps the output high continuously.
- R8: While the run bit is 0, all outputs are low and the prescaler and local counter are held at 0. After the run bit is set, every output goes high in the second cycle after the write cycle.
- R9: A duty write made while running takes effect at the next wrap of the local counter from 255 to 0. The period already under way completes with the old value.
- R10: A duty write whose write cycle coincides with the wrap cycle is not picked up by that wrap. It takes effect one full period later.
- R11: While the run bit is 0, the comparator follows the duty register directly, so duty values written while stopped apply from the first period after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after rd_en |
| irq_en | output | 1 | Stored interrupt-enable flag |
| pwm_out | output | 4 | One registered PWM output per channel |

## Verification
The case that needs care is a duty-register write landing in the same clock as the local counter wrapping. The staging register updates on that edge while the comparator latches the previous staged value. The bench produces this collision on purpose: with prescale 0, it times a write to strike exactly the wrap edge and a second write one cycle earlier. It then follows the output sample by sample over three periods. It requires the early write to apply from the second period and the colliding write only from the third.

// File: rtl/pwmsp_pkg.sv
package pwmsp_pkg;
  localparam int REG_W     = 32;
  localparam int PS_W      = 8;
  localparam int CTRL_OFF  = 'h50;
  localparam int IRQ_OFF   = 'h54;
  localparam int PS_LO_LSB = 0;
  localparam int PS_HI_LSB = 11;
  localparam int RUN_BIT   = 9;
  localparam int IRQ_BIT   = 0;
  localparam int NIB_W     = PS_W / 2;
endpackage

// File: rtl/pwmsp_regs.sv
module pwmsp_regs
  import pwmsp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [REG_W-1:0]             rdata,
  output logic [NUM_CH-1:0][CNT_W-1:0] duty,
  output logic                         run,
  output logic [PS_W-1:0]              prescale,
  output logic                         irq_en
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(CTRL_OFF / 4);
  localparam logic [WORD_W-1:0] IRQ_WORD  = WORD_W'(IRQ_OFF / 4);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              ctrl_hit;
  logic              irq_hit;
  logic [NUM_CH-1:0] duty_hit;
  logic [REG_W-1:0]  rd_next;
  logic              unused_wdata;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign ctrl_hit = aligned && (word == CTRL_WORD);
  assign irq_hit  = aligned && (word == IRQ_WORD);
  assign unused_wdata = ^wdata;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
      assign duty_hit[g] = aligned && (word == WORD_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      duty     <= '0;
      run      <= 1'b0;
      prescale <= '0;
      irq_en   <= 1'b0;
    end else if (wr_en) begin
      if (ctrl_hit) begin
        prescale <= {wdata[PS_HI_LSB +: NIB_W], wdata[PS_LO_LSB +: NIB_W]};
        run      <= wdata[RUN_BIT];
      end
      if (irq_hit) begin
        irq_en <= wdata[IRQ_BIT];
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (duty_hit[i]) begin
          duty[i] <= wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (ctrl_hit) begin
      rd_next[PS_LO_LSB +: NIB_W] = prescale[NIB_W-1:0];
      rd_next[PS_HI_LSB +: NIB_W] = prescale[PS_W-1:NIB_W];
      rd_next[RUN_BIT]            = run;
    end
    if (irq_hit) begin
      rd_next[IRQ_BIT] = irq_en;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (duty_hit[i]) begin
        rd_next[CNT_W-1:0] = duty[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/pwmsp_timebase.sv
module pwmsp_timebase #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PS_W-1:0]  prescale,
  output logic             tick,
  output logic             wrap,
  output logic [CNT_W-1:0] loc
);
  logic [PS_W-1:0] ps_cnt;

  assign tick = run && (ps_cnt >= prescale);
  assign wrap = tick && (loc == '1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ps_cnt <= '0;
      loc    <= '0;
    end else if (tick) begin
      ps_cnt <= '0;
      loc    <= loc + 1'b1;
    end else begin
      ps_cnt <= ps_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmsp_channel.sv
module pwmsp_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] loc,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] act,
  output logic             out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
      out <= 1'b0;
    end else begin
      if (!run || wrap) begin
        act <= duty;
      end
      out <= run && (loc <= act);
    end
  end
endmodule

// File: rtl/pwm_shared_period.sv
module pwm_shared_period
  import pwmsp_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq_en,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0][CNT_W-1:0] duty;
  logic [NUM_CH-1:0][CNT_W-1:0] act_duty;
  logic                         run;
  logic [PS_W-1:0]              prescale;
  logic                         tick;
  logic                         wrap;
  logic [CNT_W-1:0]             loc;

  pwmsp_regs #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .duty    (duty),
    .run     (run),
    .prescale(prescale),
    .irq_en  (irq_en)
  );

  pwmsp_timebase #(
    .CNT_W(CNT_W),
    .PS_W (PS_W)
  ) u_tb (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .prescale(prescale),
    .tick    (tick),
    .wrap    (wrap),
    .loc     (loc)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwmsp_channel #(
        .CNT_W(CNT_W)
      ) u_ch (
        .clk (clk),
        .rst (rst),
        .run (run),
        .wrap(wrap),
        .loc (loc),
        .duty(duty[c]),
        .act (act_duty[c]),
        .out (pwm_out[c])
      );
    end
  endgenerate
endmodule

// File: rtl/pwmsp_chk.sv
module pwmsp_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         run,
  input logic                         tick,
  input logic                         wrap,
  input logic [CNT_W-1:0]             loc,
  input logic [NUM_CH-1:0][CNT_W-1:0] act,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [31:0]                  rdata
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pwm_out == '0) && (rdata == '0));

  // R8
  stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == '0));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(loc));

  // R6
  count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (loc == '0));

  // R9
  staged_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(act));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_full
      // R7
      full_high_chk: assert property (@(posedge clk) disable iff (rst)
        (run && (act[c] == '1)) |=> pwm_out[c]);
    end
  endgenerate
endmodule

bind pwm_shared_period pwmsp_chk #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .run    (run),
  .tick   (tick),
  .wrap   (wrap),
  .loc    (loc),
  .act    (act_duty),
  .pwm_out(pwm_out),
  .rdata  (rdata)
);

// File: tb/pwm_shared_period_tb.sv
`timescale 1ns/1ps
module pwm_shared_period_tb;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_en;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_shared_period u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .pwm_out(pwm_out)
  );

  function automatic logic [31:0] mk_ctrl(input bit r, input logic [7:0] p);
    return (32'(p[3:0])) | (32'(p[7:4]) << 11) | (32'(r) << 9);
  endfunction

  function automatic bit exp_high(input int i, input int p, input int d);
    return (i % (256 * (p + 1))) < ((d + 1) * (p + 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  // Start from stopped state, load duties, start, then sample ns cycles.
  // Optional write of nd to channel wc at sample index wa; it must show
  // from sample sa on.
  task automatic run_wave(input int p, input logic [NCH-1:0][7:0] dv,
                          input int wa, input int wc, input logic [7:0] nd,
                          input int sa, input int ns, input string req);
    int bad [NCH];
    int first [NCH];
    for (int c = 0; c < NCH; c++) begin bad[c] = 0; first[c] = -1; end
    wr(8'h50, 32'h0);
    for (int c = 0; c < NCH; c++) wr(8'(c * 4), 32'(dv[c]));
    wr(8'h50, mk_ctrl(1'b1, 8'(p)));
    for (int i = 0; i < ns; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        int d;
        d = (c == wc && wa >= 0 && i >= sa) ? int'(nd) : int'(dv[c]);
        if (pwm_out[c] !== exp_high(i, p, d)) begin
          bad[c]++;
          if (first[c] < 0) first[c] = i;
        end
      end
      if (wa >= 0 && i == wa) begin
        wr_en = 1'b1; addr = 8'(wc * 4); wdata = 32'(nd);
      end else begin
        wr_en = 1'b0;
      end
    end
    wr_en = 1'b0;
    for (int c = 0; c < NCH; c++)
      chk(bad[c] == 0, req, $sformatf("ch%0d p=%0d first bad sample", c, p),
          first[c], -1);
    wr(8'h50, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    logic [NCH-1:0][7:0] dv;
    bit lowall;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(pwm_out == '0, "R1", "outputs after reset", pwm_out, 0);
    chk(irq_en == 1'b0, "R1", "irq_en after reset", irq_en, 0);
    chk(rdata == '0, "R1", "rdata idle", rdata, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(8'(c * 4), v); chk(v == 0, "R1", $sformatf("duty%0d reset", c), v, 0);
    end
    rd(8'h50, v); chk(v == 0, "R1", "ctrl reset", v, 0);
    rd(8'h54, v); chk(v == 0, "R1", "irq reset", v, 0);

    // R2 duty storage and width
    wr(8'h00, 32'hFFFF_FF5A);
    rd(8'h00, v); chk(v == 32'h5A, "R2", "duty0 readback", v, 32'h5A);
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] r8;
      r8 = 8'($urandom);
      wr(8'(c * 4), {24'hABCDEF, r8});
      rd(8'(c * 4), v); chk(v == 32'(r8), "R2", $sformatf("duty%0d random", c), v, r8);
    end

    // R3 control fields
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, v); chk(v == 32'h7A0F, "R3", "ctrl all ones", v, 32'h7A0F);
    wr(8'h50, mk_ctrl(1'b0, 8'hA5));
    rd(8'h50, v); chk(v == mk_ctrl(1'b0, 8'hA5), "R3", "ctrl nibbles", v, mk_ctrl(1'b0, 8'hA5));
    wr(8'h50, 32'h0);

    // R4 interrupt enable
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, v); chk(v == 1, "R4", "irq readback", v, 1);
    chk(irq_en == 1'b1, "R4", "irq_en port", irq_en, 1);
    wr(8'h54, 32'hFFFF_FFFE);
    rd(8'h54, v); chk(v == 0, "R4", "irq cleared", v, 0);
    chk(irq_en == 1'b0, "R4", "irq_en port cleared", irq_en, 0);

    // R5 unmapped and misaligned
    wr(8'h00, 32'h11);
    wr(8'h40, 32'hFF);
    wr(8'h01, 32'h77);
    wr(8'h51, 32'hFFFF);
    rd(8'h00, v); chk(v == 32'h11, "R5", "duty0 after stray writes", v, 32'h11);
    rd(8'h50, v); chk(v == 0, "R5", "ctrl after misaligned write", v, 0);
    rd(8'h40, v); chk(v == 0, "R5", "unmapped read", v, 0);
    rd(8'h58, v); chk(v == 0, "R5", "unmapped read 0x58", v, 0);
    rd(8'h02, v); chk(v == 0, "R5", "misaligned read", v, 0);

    // R8 stopped: outputs stay low with duties loaded
    for (int c = 0; c < NCH; c++) wr(8'(c * 4), 32'hFF);
    lowall = 1'b1;
    repeat (20) begin @(negedge clk); if (pwm_out != '0) lowall = 1'b0; end
    chk(lowall, "R8", "outputs while stopped", 0, 0);

    // R6 R7 R8 R11 directed corners
    dv = {8'd255, 8'd128, 8'd1, 8'd0};
    run_wave(0, dv, -1, 0, 8'd0, 0, 512, "R7");
    run_wave(2, dv, -1, 0, 8'd0, 0, 2 * 768, "R6");
    dv = {8'd7, 8'd200, 8'd254, 8'd3};
    run_wave(8'h12, dv, -1, 0, 8'd0, 0, 2 * 256 * 19, "R11");

    // R9 write one cycle before wrap: new value from second period
    dv = {8'd10, 8'd20, 8'd30, 8'd40};
    run_wave(0, dv, 253, 1, 8'd200, 256, 768, "R9");
    run_wave(0, dv, 50, 2, 8'd5, 256, 768, "R9");
    // R10 write on the wrap edge: new value only from third period
    run_wave(0, dv, 254, 1, 8'd200, 512, 768, "R10");
    run_wave(1, dv, 2 * 256 - 2, 3, 8'd255, 1024, 1536, "R10");

    // R6 R7 random
    for (int k = 0; k < 6; k++) begin
      int p;
      p = int'($urandom_range(3, 0));
      for (int c = 0; c < NCH; c++) begin
        int sel;
        sel = int'($urandom_range(5, 0));
        dv[c] = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd255 : 8'($urandom);
      end
      run_wave(p, dv, -1, 0, 8'd0, 0, 2 * 256 * (p + 1), "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule